// File: doc/BRIEF.md
# Quick-Branch Next-PC Unit

This block works out the program counter that follows the instruction now executing on a word-addressed core. The decoder supplies an operation code, the current PC, the first source register, the second register, an 8-bit immediate, a 16-bit immediate, an immediate-select bit and a signed relative offset. From these it forms the second operand and settles the next PC.

The relative forms cover the compare-and-branch family, the branch-always form and two bit-test branches. Every compare places the second operand on the left and the first register on the right. Absolute jumps load a target taken from the 16-bit immediate or from a register. The jump-and-link form also yields a return address and a strobe that lets the register file write it. Every other operation code simply steps to the next word.

The result is registered. Fetch uses it on the cycle after the inputs are presented.

Top module: `qb_next_pc`

## Requirements
- R1: While rst_ni is low, next_pc_o, link_o and link_we_o are all zero.
- R2: The operand op2 is the 8-bit immediate, zero-extended, when use_imm_i is 1. It is rs2_i when use_imm_i is 0.
- R3: Codes 1 to 6 branch when the unsigned condition holds. The conditions are op2 > rs1 (1), op2 >= rs1 (2), op2 < rs1 (3), op2 <= rs1 (4), op2 == rs1 (5) and op2 != rs1 (6).
- R4: A taken relative branch gives pc + sign-extended br_off_i. A branch that is not taken gives pc + 1. Both sums wrap at 16 bits.
- R5: Code 7 always gives pc + sign-extended br_off_i.
- R6: Code 8 is taken when bit op2[4:0] of rs1 is 1. Code 9 is taken when that bit is 0. The upper bits of op2 have no effect on the bit index.
- R7: Code 10 jumps to imm16_i when use_imm_i is 1, and to rs2_i[15:0] when use_imm_i is 0. link_we_o stays 0.
- R8: Code 11 jumps to the same target as code 10. It drives link_o to pc + 1, wrapped at 16 bits and zero-extended to 32 bits, and sets link_we_o to 1.
- R9: Code 0 and codes 12 to 15 give pc + 1 with link_we_o at 0, whatever the operands.
- R10: The outputs change one clock edge after the inputs are sampled, and each cycle's inputs are handled independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Control operation code |
| pc_i | input | 16 | Current program counter |
| rs1_i | input | 32 | First source register |
| rs2_i | input | 32 | Second source register |
| imm8_i | input | 8 | Short immediate |
| imm16_i | input | 16 | Long immediate (jump target) |
| use_imm_i | input | 1 | Selects immediates over rs2_i |
| br_off_i | input | 10 | Signed relative offset |
| next_pc_o | output | 16 | Registered next PC |
| link_o | output | 32 | Registered return address |
| link_we_o | output | 1 | Return-address write strobe |

## Verification
The bench builds the unit with its default widths: a 16-bit PC, 32-bit registers and a 10-bit offset. The 10-bit offset spans -512 to +511, so a short run of vectors can wrap the PC both below zero and above 0xFFFF. The 32-bit registers give a 5-bit bit index, which puts bit 31 and immediates with bits 5 to 7 set within reach. The full register width also lets unsigned and signed ordering be told apart with a value of 0xFFFFFFFF.

// File: rtl/qb_pkg.sv
package qb_pkg;
  typedef enum logic [3:0] {
    QB_SEQ = 4'd0,
    QB_GT  = 4'd1,
    QB_GE  = 4'd2,
    QB_LT  = 4'd3,
    QB_LE  = 4'd4,
    QB_EQ  = 4'd5,
    QB_NE  = 4'd6,
    QB_BRA = 4'd7,
    QB_BBS = 4'd8,
    QB_BBC = 4'd9,
    QB_JMP = 4'd10,
    QB_JAL = 4'd11
  } qb_op_e;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_REL = 2'd1,
    SEL_ABS = 2'd2
  } qb_sel_e;
endpackage

// File: rtl/qb_operand_sel.sv
module qb_operand_sel #(
  parameter int DATA_W  = 32,
  parameter int PC_W    = 16,
  parameter int IMM8_W  = 8,
  parameter int IMM16_W = 16
) (
  input  logic               use_imm_i,
  input  logic [IMM8_W-1:0]  imm8_i,
  input  logic [IMM16_W-1:0] imm16_i,
  input  logic [DATA_W-1:0]  rs2_i,
  output logic [DATA_W-1:0]  op2_o,
  output logic [PC_W-1:0]    jmp_tgt_o
);
  localparam int PAD8 = DATA_W - IMM8_W;

  logic [DATA_W-1:0] imm8_ext;
  logic [PC_W-1:0]   imm16_ext;
  logic [PC_W-1:0]   reg_tgt;

  assign imm8_ext  = {{PAD8{1'b0}}, imm8_i};
  assign reg_tgt   = rs2_i[PC_W-1:0];

  generate
    if (PC_W > IMM16_W) begin : g_pad16
      assign imm16_ext = {{(PC_W-IMM16_W){1'b0}}, imm16_i};
    end else begin : g_trunc16
      assign imm16_ext = imm16_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    op2_o     = use_imm_i ? imm8_ext  : rs2_i;
    jmp_tgt_o = use_imm_i ? imm16_ext : reg_tgt;
  end
endmodule

// File: rtl/qb_cond_eval.sv
module qb_cond_eval
  import qb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  qb_op_e            op_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] op2_i,
  output qb_sel_e           sel_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] bit_idx;
  logic             bit_val;
  logic             op2_gt, op2_eq;
  logic             take;

  assign bit_idx = op2_i[IDX_W-1:0];
  assign bit_val = rs1_i[bit_idx];
  // operand order is op2 against rs1
  assign op2_gt  = op2_i > rs1_i;
  assign op2_eq  = op2_i == rs1_i;

  always_comb begin
    take  = 1'b0;
    sel_o = SEL_SEQ;
    unique case (op_i)
      QB_GT:   take = op2_gt;
      QB_GE:   take = op2_gt | op2_eq;
      QB_LT:   take = ~op2_gt & ~op2_eq;
      QB_LE:   take = ~op2_gt;
      QB_EQ:   take = op2_eq;
      QB_NE:   take = ~op2_eq;
      QB_BRA:  take = 1'b1;
      QB_BBS:  take = bit_val;
      QB_BBC:  take = ~bit_val;
      default: take = 1'b0;
    endcase
    if (op_i == QB_JMP || op_i == QB_JAL) sel_o = SEL_ABS;
    else if (take)                         sel_o = SEL_REL;
  end
endmodule

// File: rtl/qb_pc_adder.sv
module qb_pc_adder #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 10
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  seq_o,
  output logic [PC_W-1:0]  rel_o,
  output logic [PC_W-1:0]  off_ext_o
);
  generate
    if (PC_W > OFF_W) begin : g_sext
      assign off_ext_o = {{(PC_W-OFF_W){off_i[OFF_W-1]}}, off_i};
    end else begin : g_trunc
      assign off_ext_o = off_i[PC_W-1:0];
    end
  endgenerate

  assign seq_o = pc_i + PC_W'(1);
  assign rel_o = pc_i + off_ext_o;
endmodule

// File: rtl/qb_next_pc.sv
module qb_next_pc
  import qb_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int DATA_W  = 32,
  parameter int IMM8_W  = 8,
  parameter int IMM16_W = 16,
  parameter int OFF_W   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         op_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [DATA_W-1:0]  rs1_i,
  input  logic [DATA_W-1:0]  rs2_i,
  input  logic [IMM8_W-1:0]  imm8_i,
  input  logic [IMM16_W-1:0] imm16_i,
  input  logic               use_imm_i,
  input  logic [OFF_W-1:0]   br_off_i,
  output logic [PC_W-1:0]    next_pc_o,
  output logic [DATA_W-1:0]  link_o,
  output logic               link_we_o
);
  localparam int LPAD = DATA_W - PC_W;

  qb_op_e            op;
  logic [DATA_W-1:0] op2;
  logic [PC_W-1:0]   jmp_tgt;
  logic [PC_W-1:0]   seq_pc, rel_pc, off_ext;
  qb_sel_e           sel;
  logic [PC_W-1:0]   npc_d;
  logic              is_jal;

  assign op     = qb_op_e'(op_i);
  assign is_jal = (op == QB_JAL);

  qb_operand_sel #(
    .DATA_W(DATA_W), .PC_W(PC_W), .IMM8_W(IMM8_W), .IMM16_W(IMM16_W)
  ) u_opsel (
    .use_imm_i(use_imm_i), .imm8_i(imm8_i), .imm16_i(imm16_i),
    .rs2_i(rs2_i), .op2_o(op2), .jmp_tgt_o(jmp_tgt)
  );

  qb_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .op_i(op), .rs1_i(rs1_i), .op2_i(op2), .sel_o(sel)
  );

  qb_pc_adder #(.PC_W(PC_W), .OFF_W(OFF_W)) u_add (
    .pc_i(pc_i), .off_i(br_off_i),
    .seq_o(seq_pc), .rel_o(rel_pc), .off_ext_o(off_ext)
  );

  always_comb begin
    unique case (sel)
      SEL_REL: npc_d = rel_pc;
      SEL_ABS: npc_d = jmp_tgt;
      default: npc_d = seq_pc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o <= '0;
      link_o    <= '0;
      link_we_o <= 1'b0;
    end else begin
      next_pc_o <= npc_d;
      link_o    <= is_jal ? {{LPAD{1'b0}}, seq_pc} : '0;
      link_we_o <= is_jal;
    end
  end

  // one edge out of reset before $past refers to live inputs
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (next_pc_o == '0 && link_we_o == 1'b0 && link_o == '0));

  p_rel_two_way_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(op_i) >= 4'd1 && $past(op_i) <= 4'd9 |->
      (next_pc_o == $past(pc_i) + PC_W'(1)) ||
      (next_pc_o == $past(pc_i) + $past(off_ext)));

  p_bra_always_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(op_i) == 4'd7 |-> next_pc_o == $past(pc_i) + $past(off_ext));

  p_jump_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ($past(op_i) == 4'd10 || $past(op_i) == 4'd11) |->
      next_pc_o == $past(jmp_tgt));

  p_link_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (link_we_o == ($past(op_i) == 4'd11)));

  p_link_value_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> link_o[PC_W-1:0] == $past(pc_i) + PC_W'(1));

  p_plain_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ($past(op_i) == 4'd0 || $past(op_i) >= 4'd12) |->
      (next_pc_o == $past(pc_i) + PC_W'(1) && !link_we_o));
endmodule

// File: tb/qb_next_pc_test.sv
`timescale 1ns/1ps
module qb_next_pc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] pc = '0;
  logic [31:0] rs1 = '0, rs2 = '0;
  logic [7:0]  imm8 = '0;
  logic [15:0] imm16 = '0;
  logic        ui = 1'b0;
  logic [9:0]  off = '0;
  logic [15:0] npc;
  logic [31:0] lnk;
  logic        lwe;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [15:0] q_pc[$];
  logic [31:0] q_lnk[$];
  logic        q_we[$];
  string       q_req[$];

  always #5 clk = ~clk;

  qb_next_pc uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .pc_i(pc), .rs1_i(rs1),
    .rs2_i(rs2), .imm8_i(imm8), .imm16_i(imm16), .use_imm_i(ui),
    .br_off_i(off), .next_pc_o(npc), .link_o(lnk), .link_we_o(lwe)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: applies one vector and queues the expected result
  task automatic apply(string req, logic [3:0] o, logic [15:0] p, logic [31:0] a,
                       logic [31:0] b, logic [7:0] i8, logic [15:0] i16,
                       logic u, logic [9:0] f);
    logic [31:0] o2;
    logic [15:0] seq, rel, enpc;
    bit t;
    @(negedge clk);
    op = o; pc = p; rs1 = a; rs2 = b; imm8 = i8; imm16 = i16; ui = u; off = f;
    o2  = u ? {24'd0, i8} : b;
    seq = p + 16'd1;
    rel = p + {{6{f[9]}}, f};
    t = 1'b0;
    case (o)
      4'd1: t = o2 > a;
      4'd2: t = o2 >= a;
      4'd3: t = o2 < a;
      4'd4: t = o2 <= a;
      4'd5: t = o2 == a;
      4'd6: t = o2 != a;
      4'd7: t = 1'b1;
      4'd8: t = a[o2[4:0]];
      4'd9: t = !a[o2[4:0]];
      default: t = 1'b0;
    endcase
    if (o == 4'd10 || o == 4'd11) enpc = u ? i16 : b[15:0];
    else                          enpc = t ? rel : seq;
    q_pc.push_back(enpc);
    q_lnk.push_back(o == 4'd11 ? {16'd0, seq} : 32'd0);
    q_we.push_back(o == 4'd11);
    q_req.push_back(req);
  endtask

  // monitor: result appears after the edge that samples the vector
  always begin
    @(posedge clk);
    #1;
    if (q_pc.size() > 0) begin
      string r;
      r = q_req.pop_front();
      check(r, "next_pc", {16'd0, npc}, {16'd0, q_pc.pop_front()});
      check(r, "link", lnk, q_lnk.pop_front());
      check(r, "link_we", {31'd0, lwe}, {31'd0, q_we.pop_front()});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    op = 4'd11; pc = 16'h1234; ui = 1'b1; imm16 = 16'h5555;
    repeat (3) @(negedge clk);
    // R1 reset state holds despite live inputs
    check("R1", "next_pc", {16'd0, npc}, 32'd0);
    check("R1", "link", lnk, 32'd0);
    check("R1", "link_we", {31'd0, lwe}, 32'd0);
    op = 4'd0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R3 six compares, op2 against rs1
    apply("R3", 4'd1, 16'd100, 32'd5, 32'd0, 8'd9, 16'd0, 1'b1, 10'd20);
    apply("R3", 4'd1, 16'd100, 32'd9, 32'd0, 8'd9, 16'd0, 1'b1, 10'd20);
    apply("R3", 4'd2, 16'd100, 32'd9, 32'd0, 8'd9, 16'd0, 1'b1, 10'd20);
    apply("R3", 4'd2, 16'd100, 32'd10, 32'd0, 8'd9, 16'd0, 1'b1, 10'd20);
    apply("R3", 4'd3, 16'd200, 32'd5, 32'd0, 8'd3, 16'd0, 1'b1, 10'd7);
    apply("R3", 4'd3, 16'd200, 32'd3, 32'd0, 8'd5, 16'd0, 1'b1, 10'd7);
    apply("R3", 4'd4, 16'd200, 32'd5, 32'd0, 8'd5, 16'd0, 1'b1, 10'd7);
    apply("R3", 4'd4, 16'd200, 32'd4, 32'd0, 8'd5, 16'd0, 1'b1, 10'd7);
    apply("R3", 4'd5, 16'd300, 32'd77, 32'd0, 8'd77, 16'd0, 1'b1, 10'd3);
    apply("R3", 4'd5, 16'd300, 32'd78, 32'd0, 8'd77, 16'd0, 1'b1, 10'd3);
    apply("R3", 4'd6, 16'd300, 32'd78, 32'd0, 8'd77, 16'd0, 1'b1, 10'd3);
    apply("R3", 4'd6, 16'd300, 32'd77, 32'd0, 8'd77, 16'd0, 1'b1, 10'd3);
    // R3 unsigned: all-ones rs1 is the largest value
    apply("R3", 4'd1, 16'd50, 32'hFFFF_FFFF, 32'd1, 8'd0, 16'd0, 1'b0, 10'd4);
    apply("R3", 4'd3, 16'd50, 32'hFFFF_FFFF, 32'd1, 8'd0, 16'd0, 1'b0, 10'd4);
    // R2 operand select: register differs from immediate
    apply("R2", 4'd5, 16'd60, 32'h0001_0005, 32'h0001_0005, 8'd5, 16'd0, 1'b0, 10'd8);
    apply("R2", 4'd5, 16'd60, 32'h0001_0005, 32'h0001_0005, 8'd5, 16'd0, 1'b1, 10'd8);
    // R4 negative offset and wrap below zero, wrap above top
    apply("R4", 4'd6, 16'd5, 32'd1, 32'd0, 8'd2, 16'd0, 1'b1, 10'h3F6);
    apply("R4", 4'd5, 16'hFFFF, 32'd1, 32'd0, 8'd2, 16'd0, 1'b1, 10'h3F6);
    apply("R4", 4'd6, 16'hFFF0, 32'd1, 32'd0, 8'd2, 16'd0, 1'b1, 10'h1FF);
    // R5 branch always, extreme offsets
    apply("R5", 4'd7, 16'hFF00, 32'd0, 32'd0, 8'd0, 16'd0, 1'b1, 10'h1FF);
    apply("R5", 4'd7, 16'h0100, 32'd0, 32'd0, 8'd0, 16'd0, 1'b0, 10'h200);
    // R6 bit tests, bit 31 and masked index
    apply("R6", 4'd8, 16'd400, 32'h8000_0000, 32'd0, 8'd31, 16'd0, 1'b1, 10'd12);
    apply("R6", 4'd8, 16'd400, 32'h8000_0000, 32'd0, 8'd63, 16'd0, 1'b1, 10'd12);
    apply("R6", 4'd8, 16'd400, 32'h7FFF_FFFF, 32'd0, 8'd31, 16'd0, 1'b1, 10'd12);
    apply("R6", 4'd9, 16'd400, 32'h8000_0000, 32'd0, 8'hFF, 16'd0, 1'b1, 10'd12);
    apply("R6", 4'd9, 16'd400, 32'hFFFF_FFFE, 32'd0, 8'd0, 16'd0, 1'b1, 10'd12);
    apply("R6", 4'd8, 16'd400, 32'h0000_0400, 32'h0000_00EA, 8'd0, 16'd0, 1'b0, 10'd12);
    // R7 absolute jumps
    apply("R7", 4'd10, 16'd500, 32'd0, 32'h1234_ABCD, 8'd0, 16'hBEEF, 1'b1, 10'd1);
    apply("R7", 4'd10, 16'd500, 32'd0, 32'h1234_ABCD, 8'd0, 16'hBEEF, 1'b0, 10'd1);
    // R8 jump-and-link, including return-address wrap
    apply("R8", 4'd11, 16'd700, 32'd0, 32'd0, 8'd0, 16'h0042, 1'b1, 10'd0);
    apply("R8", 4'd11, 16'hFFFF, 32'd0, 32'h0000_9876, 8'd0, 16'h0042, 1'b0, 10'd0);
    // R9 plain codes ignore operands that would take a branch
    apply("R9", 4'd0, 16'd800, 32'd0, 32'd9, 8'd9, 16'h7777, 1'b1, 10'd99);
    apply("R9", 4'd12, 16'd801, 32'd0, 32'd9, 8'd9, 16'h7777, 1'b1, 10'd99);
    apply("R9", 4'd15, 16'hFFFF, 32'd0, 32'd9, 8'd9, 16'h7777, 1'b0, 10'd99);
    // R10 back-to-back: link strobe drops after one cycle
    apply("R10", 4'd11, 16'd900, 32'd0, 32'd0, 8'd0, 16'h0123, 1'b1, 10'd0);
    apply("R10", 4'd13, 16'h0123, 32'd0, 32'd0, 8'd0, 16'h0000, 1'b1, 10'd0);
    apply("R10", 4'd7, 16'h0124, 32'd0, 32'd0, 8'd0, 16'h0000, 1'b1, 10'h3FF);

    @(negedge clk); op = 4'd0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule